// File: doc/BRIEF.md
# Outstanding Accept Occupancy Counter with Threshold Flags

This block tracks how many first-stage trigger accepts are still waiting for their second-stage decision. Each accept strobe raises an occupancy count by one. Each decision strobe lowers it by one. The count is presented on a parallel output so that readout logic can sample it at any time.

Four comparators watch the count, one for each programmable threshold. Each one raises a flag while the count is strictly greater than its threshold. The flags are registered and come out as separate wires, so trigger logic can use them as live input terms. Thresholds are loaded through a small write port with an address and a data word, and the addressed threshold can be read back on a combinational data output. A synchronous initialization input empties the counter and clears a sticky underflow error flag. It leaves the thresholds as they were.

Top module: `pending_accept_counter`

## Requirements
- R1: After reset the count is 0, all four flags are 0, the error flag is 0, and every threshold reads back as 16'hFFFF.
- R2: An accept strobe without a decision strobe raises the count by one at the next clock edge.
- R3: A decision strobe without an accept strobe lowers the count by one at the next clock edge when the count is above 0.
- R4: An accept and a decision in the same cycle leave the count unchanged.
- R5: A lone decision while the count is 0 keeps the count at 0 and sets the error flag. The error flag then stays at 1 under any strobes until initialization.
- R6: The count stops at 16'hFFFF. A lone accept at that value leaves it unchanged.
- R7: Flag bit i (i = 0..3) is 1 exactly when the count is strictly greater than threshold i. It is registered, so it shows the count and threshold of the previous cycle.
- R8: With the write enable high, the data word is stored at the next edge into the threshold selected by the 2-bit address (0..3). The read data output always shows the threshold selected by the address.
- R9: Initialization clears the count and the error flag at the next edge, whatever strobes arrive with it, and all thresholds keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_i | input | 1 | Synchronous initialization: clears count and error |
| acc_stb_i | input | 1 | First-stage accept strobe, one per accept |
| dec_stb_i | input | 1 | Second-stage decision strobe, one per decision |
| cfg_we_i | input | 1 | Threshold write enable |
| cfg_addr_i | input | 2 | Threshold index for write and read-back |
| cfg_wdata_i | input | 16 | Threshold value to write |
| cfg_rdata_o | output | 16 | Threshold value at cfg_addr_i |
| count_o | output | 16 | Current occupancy count |
| above_o | output | 4 | Bit i set while count exceeds threshold i |
| underflow_o | output | 1 | Sticky error: decision received at zero count |

## Verification
The checker verifies the single-cycle counting rules on every cycle: increment, decrement, hold on simultaneous strobes, clamping at zero and at full scale, initialization priority, and error stickiness. It also checks the one-cycle lag between each flag and its comparison. Some behaviours can only be shown by the bench's scenarios. These are that the flags line up with the intended thresholds over a full sweep of small counts, that a threshold write lands in the addressed slot and survives initialization, and that the count really reaches full scale after a long run of accepts.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    OCC_HOLD  = 2'd0,
    OCC_UP    = 2'd1,
    OCC_DOWN  = 2'd2,
    OCC_CLEAR = 2'd3
  } occ_op_e;
endpackage

// File: rtl/pac_occupancy.sv
module pac_occupancy
  import pac_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             acc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  occ_op_e          op;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             upd_en;

  always_comb begin
    if (init_i)              op = OCC_CLEAR;
    else if (acc_i && !dec_i) op = OCC_UP;
    else if (dec_i && !acc_i) op = OCC_DOWN;
    else                     op = OCC_HOLD;
  end

  always_comb begin
    cnt_d  = cnt_q;
    err_d  = err_q;
    unique case (op)
      OCC_CLEAR: begin
        cnt_d = '0;
        err_d = 1'b0;
      end
      OCC_UP: begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      OCC_DOWN: begin
        if (cnt_q == '0) err_d = 1'b1;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ;
    endcase
  end

  assign upd_en = (op != OCC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign count_o     = cnt_q;
  assign underflow_o = err_q;
endmodule

// File: rtl/pac_thr_regs.sv
module pac_thr_regs #(
  parameter int CNT_W  = 16,
  parameter int N_THR  = 4,
  parameter int ADDR_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CNT_W-1:0]            wdata_i,
  output logic [N_THR-1:0][CNT_W-1:0] thr_o,
  output logic [CNT_W-1:0]            rdata_o
);
  logic [N_THR-1:0][CNT_W-1:0] thr_q;

  for (genvar gi = 0; gi < N_THR; gi++) begin : g_slot
    logic wr_en;
    assign wr_en = we_i && (addr_i == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     thr_q[gi] <= '1;
      else if (wr_en) thr_q[gi] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_THR; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = thr_q[i];
    end
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/pac_cmp_bank.sv
module pac_cmp_bank #(
  parameter int CNT_W = 16,
  parameter int N_THR = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W-1:0]            count_i,
  input  logic [N_THR-1:0][CNT_W-1:0] thr_i,
  output logic [N_THR-1:0]            above_o
);
  logic [N_THR-1:0] above_d, above_q;

  for (genvar gi = 0; gi < N_THR; gi++) begin : g_cmp
    assign above_d[gi] = (count_i > thr_i[gi]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= '0;
    else        above_q <= above_d;
  end

  assign above_o = above_q;
endmodule

// File: rtl/pending_accept_counter.sv
module pending_accept_counter #(
  parameter int CNT_W  = 16,
  parameter int N_THR  = 4,
  parameter int ADDR_W = $clog2(N_THR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              acc_stb_i,
  input  logic              dec_stb_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic [CNT_W-1:0]  cfg_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_THR-1:0]  above_o,
  output logic              underflow_o
);
  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  logic [N_THR-1:0][CNT_W-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pac_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_i     (init_i),
    .acc_i      (acc_stb_i),
    .dec_i      (dec_stb_i),
    .count_o    (count_o),
    .underflow_o(underflow_o)
  );

  pac_thr_regs #(.CNT_W(CNT_W), .N_THR(N_THR), .ADDR_W(ADDR_W)) u_thr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .thr_o  (thr),
    .rdata_o(cfg_rdata_o)
  );

  pac_cmp_bank #(.CNT_W(CNT_W), .N_THR(N_THR)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .count_i(count_o),
    .thr_i  (thr),
    .above_o(above_o)
  );
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int CNT_W = 16,
  parameter int N_THR = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        init_i,
  input logic                        acc_i,
  input logic                        dec_i,
  input logic [CNT_W-1:0]            count,
  input logic                        err,
  input logic [N_THR-1:0]            above,
  input logic [N_THR-1:0][CNT_W-1:0] thr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && acc_i && !dec_i && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && dec_i && !acc_i && count != '0) |=> count == $past(count) - 1'b1);

  // R4
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && acc_i && dec_i) |=> $stable(count));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && dec_i && !acc_i && count == '0) |=> (count == '0 && err));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !init_i) |=> err);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && acc_i && !dec_i && count == CNT_MAX) |=> count == CNT_MAX);

  // R9
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (count == '0 && !err));

  for (genvar gi = 0; gi < N_THR; gi++) begin : g_flag
    // R7
    flag_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> above[gi] == ($past(count) > $past(thr[gi])));
  end
endmodule

bind pending_accept_counter pac_checker #(.CNT_W(CNT_W), .N_THR(N_THR)) u_pac_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .init_i(init_i),
  .acc_i (acc_stb_i),
  .dec_i (dec_stb_i),
  .count (count_o),
  .err   (underflow_o),
  .above (above_o),
  .thr   (thr)
);

// File: tb/pending_accept_counter_bench.sv
`timescale 1ns/1ps
module pending_accept_counter_bench;
  localparam int CW = 16;
  localparam int NT = 4;
  localparam int MAXV = 65535;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_i, acc, dec, we;
  logic [1:0]    addr;
  logic [CW-1:0] wdata, rdata, count;
  logic [NT-1:0] above;
  logic          err;

  int n_chk = 0;
  int n_bad = 0;
  int m = 0;
  logic merr = 1'b0;
  int tm [NT];

  always #10 clk = ~clk;

  pending_accept_counter u_pending_accept_counter (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .acc_stb_i(acc), .dec_stb_i(dec),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .count_o(count), .above_o(above), .underflow_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_flags();
    int f = 0;
    for (int i = 0; i < NT; i++) if (m > tm[i]) f |= (1 << i);
    return f;
  endfunction

  task automatic cyc(input logic a, input logic d, input logic ini);
    acc = a; dec = d; init_i = ini;
    @(negedge clk);
    acc = 1'b0; dec = 1'b0; init_i = 1'b0;
    if (ini) begin m = 0; merr = 1'b0; end
    else if (a && !d) begin if (m != MAXV) m = m + 1; end
    else if (d && !a) begin if (m == 0) merr = 1'b1; else m = m - 1; end
  endtask

  task automatic wr(input int idx, input int v);
    we = 1'b1; addr = 2'(idx); wdata = CW'(v);
    @(negedge clk);
    we = 1'b0;
    tm[idx] = v;
  endtask

  task automatic check_state(input string req);
    check({req, " count"}, int'(count), m);
    check({req, " err"}, int'(err), int'(merr));
    @(negedge clk);
    check({"R7 flags after ", req}, int'(above), exp_flags());
  endtask

  task automatic check_thr(input string req);
    for (int i = 0; i < NT; i++) begin
      addr = 2'(i); #1;
      check(req, int'(rdata), tm[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_i = 1'b0; acc = 1'b0; dec = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < NT; i++) tm[i] = MAXV;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 flags", int'(above), 0);
    check("R1 err", int'(err), 0);
    check_thr("R1 threshold reset");

    // R8 program small thresholds
    wr(0, 0); wr(1, 2); wr(2, 5); wr(3, 9);
    check_thr("R8 readback");
    @(negedge clk);

    // R2 / R7 / R4 sweep upward
    for (int k = 0; k < 12; k++) begin
      cyc(1'b1, 1'b0, 1'b0);
      check_state("R2 up");
      cyc(1'b1, 1'b1, 1'b0);
      check_state("R4 both");
    end

    // R7 one-cycle lag: count 12 -> 13 with threshold 3 at 12
    wr(3, 12);
    @(negedge clk);
    cyc(1'b1, 1'b0, 1'b0);
    check("R7 lag count", int'(count), 13);
    check("R7 lag old flag", int'(above[3]), 0);
    @(negedge clk);
    check("R7 lag new flag", int'(above[3]), 1);
    wr(3, 9);
    @(negedge clk);

    // R3 sweep downward
    while (m > 0) begin
      cyc(1'b0, 1'b1, 1'b0);
      check_state("R3 down");
    end

    // R5 decision at zero, then stickiness
    cyc(1'b0, 1'b1, 1'b0);
    check_state("R5 underflow");
    cyc(1'b1, 1'b1, 1'b0);
    check_state("R5 both at zero");
    cyc(1'b1, 1'b0, 1'b0);
    check_state("R5 sticky after accept");

    // R6 saturation at full scale
    wr(0, 65534); wr(1, 65535); wr(2, 0); wr(3, 32768);
    acc = 1'b1;
    repeat (MAXV - m) @(negedge clk);
    acc = 1'b0;
    m = MAXV;
    check_state("R6 full");
    cyc(1'b1, 1'b0, 1'b0);
    check_state("R6 saturate");
    cyc(1'b0, 1'b1, 1'b0);
    check_state("R3 from full");
    check("R5 still set", int'(err), 1);

    // R9 init wins over strobes, thresholds kept
    cyc(1'b1, 1'b0, 1'b1);
    check_state("R9 init");
    cyc(1'b0, 1'b1, 1'b1);
    check_state("R9 init with decision");
    check_thr("R9 thresholds kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule